// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-level control and status registers of a 32-bit integer core and decides, once per cycle, whether the instruction sitting in the memory access slot completes normally, traps, or returns from a trap. It runs the six atomic CSR read-modify-write operations, in register and 5-bit immediate form. Each returns the register's previous contents, to be written to the destination register.

Earlier stages pass in exception flags for the instruction in the slot. Three interrupt request lines come from outside. When a trap is taken, the unit raises a flush request in the same cycle and gives the handler address. On the next clock edge it records the cause, the faulting PC and the trap value. A trap-return request restores the interrupt enable and redirects the core to the saved PC. Decoding, interrupt and timer peripherals, and lower privilege levels belong to other blocks.

Top module: `csr_trap_unit`

## Requirements
- R1: Operation codes on `csr_op` are 3'b001 write, 3'b010 set bits, 3'b011 clear bits, and 3'b101/3'b110/3'b111 for the same three with the zero-extended `src_field` as operand. `csr_rdata` always shows the register's value before the operation. The register then holds the operand, old|operand, or old&~operand.
- R2: A set or clear operation whose `src_field` is zero (source x0 or zero immediate) writes nothing, even if `rs1_val` is non-zero.
- R3: An access to an unimplemented address raises illegal instruction (cause 2) and changes no register. So does a write to a read-only register: 0xF14 hart id, which reads 0, or 0x344 pending bits. Implemented addresses are 0x300 status, 0x304 enables, 0x305 vector, 0x340 scratch, 0x341 saved PC, 0x342 cause, 0x343 trap value, 0x344 pending and 0xF14.
- R4: Exception causes are instruction address misaligned 0, illegal 2, breakpoint 3, load misaligned 4, store misaligned 6 and environment call 11. When several are raised, the priority order is misaligned fetch, illegal, breakpoint, environment call, load, store. Any exception beats any interrupt.
- R5: An interrupt is taken only when status bit 3 and its enable bit are both set. The enable bits are 11 for external, 7 for timer and 3 for software, and reads of 0x344 show the live request lines at the same positions. External beats software, and software beats timer. The cause is bit 31 set with code 11, 3 or 7.
- R6: On a trap, `trap_take` rises in the same cycle and `trap_target` is the vector base with its low two bits zero. Afterwards the saved PC is the slot PC with bit 0 cleared, status bit 7 holds the old bit 3, and bit 3 is clear. Status bits 12:11 always read 2'b11.
- R7: The trap value becomes `fault_addr` for the three misaligned causes, and zero for every other trap.
- R8: A trap return with no trap raises `ret_take`, with `ret_target` equal to the saved PC. It then copies status bit 7 into bit 3 and sets bit 7.
- R9: After reset, status reads 0x1800, and enables, vector, saved PC, cause and trap value read 0.
- R10: While `stage_valid` is low, no trap, return or CSR write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_valid | input | 1 | Memory-access slot holds a live instruction |
| pc | input | 32 | PC of the slot instruction |
| csr_valid | input | 1 | Slot instruction is a CSR operation |
| csr_op | input | 3 | CSR operation code |
| csr_addr | input | 12 | CSR address |
| src_field | input | 5 | Source register index or immediate |
| rs1_val | input | 32 | Source register value |
| csr_rdata | output | 32 | Previous CSR value |
| exc_iaddr_mis | input | 1 | Misaligned fetch target |
| exc_illegal | input | 1 | Illegal instruction from decode |
| exc_ebreak | input | 1 | Breakpoint instruction |
| exc_ecall | input | 1 | Environment call instruction |
| exc_ld_mis | input | 1 | Misaligned load address |
| exc_st_mis | input | 1 | Misaligned store address |
| fault_addr | input | 32 | Offending address for misaligned faults |
| mret | input | 1 | Trap-return instruction |
| irq_ext | input | 1 | External interrupt request |
| irq_tmr | input | 1 | Timer interrupt request |
| irq_sw | input | 1 | Software interrupt request |
| trap_take | output | 1 | Trap taken, flush pipeline |
| trap_target | output | 32 | Handler address |
| ret_take | output | 1 | Trap return taken |
| ret_target | output | 32 | Return address |

## Verification
Each of the six operations is tried against the scratch register over several old/operand bit patterns, with both zero and non-zero source fields. This separates the write, set and clear arithmetic, and the immediate from the register source, and shows that the zero-source gate stops writes. All seven non-empty mixes of interrupt lines are tried with enables on, which checks the interrupt priority order. The same lines are then tried with the global or per-source enable off. Every exception is raised alone to check its code and trap value, and in pairs, including paired with an interrupt, to check priority. Trap return is run with both old values of the saved enable bit.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;
    localparam int XLEN = 32;
    localparam int NEXC = 6;
    localparam int NIRQ = 3;
    localparam int FW   = 5;

    // exception slots, lowest index = highest priority
    localparam int X_IMIS = 0;
    localparam int X_ILL  = 1;
    localparam int X_BRK  = 2;
    localparam int X_ENV  = 3;
    localparam int X_LMIS = 4;
    localparam int X_SMIS = 5;
    // interrupt slots, lowest index = highest priority
    localparam int I_EXT = 0;
    localparam int I_SW  = 1;
    localparam int I_TMR = 2;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_IEN     = 12'h304;
    localparam logic [11:0] A_VEC     = 12'h305;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_PEND    = 12'h344;
    localparam logic [11:0] A_HART    = 12'hF14;

    typedef enum logic [2:0] {
        OP_RW = 3'b001, OP_RS = 3'b010, OP_RC = 3'b011,
        OP_RWI = 3'b101, OP_RSI = 3'b110, OP_RCI = 3'b111
    } csr_op_e;

    typedef struct packed {
        logic            gie;
        logic            pie;
        logic [2:0]      ien;     // {ext, tmr, sw}
        logic [XLEN-3:0] vbase;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } csr_state_t;

    function automatic logic [4:0] exc_code(input int i);
        case (i)
            X_IMIS:  return 5'd0;
            X_ILL:   return 5'd2;
            X_BRK:   return 5'd3;
            X_ENV:   return 5'd11;
            X_LMIS:  return 5'd4;
            default: return 5'd6;
        endcase
    endfunction

    function automatic logic [4:0] irq_code(input int i);
        case (i)
            I_EXT:   return 5'd11;
            I_SW:    return 5'd3;
            default: return 5'd7;
        endcase
    endfunction
endpackage

// File: rtl/csr_trap_alu.sv
module csr_trap_alu
    import csr_trap_pkg::*;
(
    input  logic [2:0]      op,
    input  logic [FW-1:0]   field,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] new_val,
    output logic            wants_write,
    output logic            op_ok
);
    logic [XLEN-1:0] src;

    always_comb begin
        src = op[2] ? XLEN'(field) : rs1_val;
        new_val = old_val;
        wants_write = 1'b0;
        op_ok = 1'b1;
        case (op[1:0])
            2'b01: begin new_val = src;            wants_write = 1'b1; end
            2'b10: begin new_val = old_val | src;  wants_write = (field != '0); end
            2'b11: begin new_val = old_val & ~src; wants_write = (field != '0); end
            default: op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/csr_trap_prio.sv
module csr_trap_prio
    import csr_trap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NEXC-1:0]      exc,
    input  logic [NIRQ-1:0]      irq,
    output logic [NEXC+NIRQ-1:0] grant,
    output logic                 take,
    output logic                 is_irq
);
    always_comb begin
        grant = '0;
        for (int i = NIRQ - 1; i >= 0; i--)
            if (irq[i]) begin grant = '0; grant[NEXC+i] = 1'b1; end
        for (int i = NEXC - 1; i >= 0; i--)
            if (exc[i]) begin grant = '0; grant[i] = 1'b1; end
        take   = |grant;
        is_irq = |grant[NEXC +: NIRQ];
    end

    // R4
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
    // R4
    exc_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) (|exc) |-> !is_irq);
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
    import csr_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage_valid,
    input  logic [31:0]      pc,
    input  logic             csr_valid,
    input  logic [2:0]       csr_op,
    input  logic [11:0]      csr_addr,
    input  logic [4:0]       src_field,
    input  logic [31:0]      rs1_val,
    output logic [31:0]      csr_rdata,
    input  logic             exc_iaddr_mis,
    input  logic             exc_illegal,
    input  logic             exc_ebreak,
    input  logic             exc_ecall,
    input  logic             exc_ld_mis,
    input  logic             exc_st_mis,
    input  logic [31:0]      fault_addr,
    input  logic             mret,
    input  logic             irq_ext,
    input  logic             irq_tmr,
    input  logic             irq_sw,
    output logic             trap_take,
    output logic [31:0]      trap_target,
    output logic             ret_take,
    output logic [31:0]      ret_target
);
    csr_state_t q, d;

    logic [XLEN-1:0]      old_val, new_val, cause_v;
    logic                 hit, ro, wants_write, op_ok, csr_bad, is_irq, do_write;
    logic [NEXC-1:0]      exc_v;
    logic [NIRQ-1:0]      irq_v;
    logic [NEXC+NIRQ-1:0] grant;

    // read mux and address decode
    always_comb begin
        old_val = '0;
        hit = 1'b1;
        ro  = 1'b0;
        case (csr_addr)
            A_STATUS:  begin old_val[12:11] = 2'b11; old_val[7] = q.pie; old_val[3] = q.gie; end
            A_IEN:     begin old_val[11] = q.ien[2]; old_val[7] = q.ien[1]; old_val[3] = q.ien[0]; end
            A_VEC:     old_val = {q.vbase, 2'b00};
            A_SCRATCH: old_val = q.scratch;
            A_EPC:     old_val = q.epc;
            A_CAUSE:   old_val = q.cause;
            A_TVAL:    old_val = q.tval;
            A_PEND:    begin old_val[11] = irq_ext; old_val[7] = irq_tmr; old_val[3] = irq_sw; ro = 1'b1; end
            A_HART:    ro = 1'b1;
            default:   hit = 1'b0;
        endcase
    end

    csr_trap_alu i_alu (
        .op(csr_op), .field(src_field), .rs1_val(rs1_val), .old_val(old_val),
        .new_val(new_val), .wants_write(wants_write), .op_ok(op_ok)
    );

    always_comb begin
        csr_bad = csr_valid && (!hit || !op_ok || (wants_write && ro));
        exc_v = '0;
        exc_v[X_IMIS] = exc_iaddr_mis;
        exc_v[X_ILL]  = exc_illegal || csr_bad;
        exc_v[X_BRK]  = exc_ebreak;
        exc_v[X_ENV]  = exc_ecall;
        exc_v[X_LMIS] = exc_ld_mis;
        exc_v[X_SMIS] = exc_st_mis;
        exc_v = exc_v & {NEXC{stage_valid}};
        irq_v = '0;
        irq_v[I_EXT] = irq_ext && q.ien[2];
        irq_v[I_SW]  = irq_sw  && q.ien[0];
        irq_v[I_TMR] = irq_tmr && q.ien[1];
        irq_v = irq_v & {NIRQ{stage_valid && q.gie}};
    end

    csr_trap_prio i_prio (
        .clk(clk), .rst_n(rst_n), .exc(exc_v), .irq(irq_v),
        .grant(grant), .take(trap_take), .is_irq(is_irq)
    );

    // next-state computation
    always_comb begin
        cause_v = '0;
        for (int i = 0; i < NEXC; i++)
            if (grant[i]) cause_v[4:0] = exc_code(i);
        for (int i = 0; i < NIRQ; i++)
            if (grant[NEXC+i]) cause_v[4:0] = irq_code(i);
        cause_v[XLEN-1] = is_irq;

        ret_take = stage_valid && mret && !trap_take;
        do_write = stage_valid && csr_valid && wants_write && !trap_take;

        d = q;
        if (trap_take) begin
            d.cause = cause_v;
            d.epc   = pc & ~XLEN'(1);
            d.tval  = (grant[X_IMIS] || grant[X_LMIS] || grant[X_SMIS]) ? fault_addr : '0;
            d.pie   = q.gie;
            d.gie   = 1'b0;
        end else if (ret_take) begin
            d.gie = q.pie;
            d.pie = 1'b1;
        end else if (do_write) begin
            case (csr_addr)
                A_STATUS:  begin d.gie = new_val[3]; d.pie = new_val[7]; end
                A_IEN:     d.ien = {new_val[11], new_val[7], new_val[3]};
                A_VEC:     d.vbase = new_val[XLEN-1:2];
                A_SCRATCH: d.scratch = new_val;
                A_EPC:     d.epc = new_val & ~XLEN'(1);
                A_CAUSE:   d.cause = new_val;
                A_TVAL:    d.tval = new_val;
                default:   d = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign csr_rdata   = old_val;
    assign trap_target = {q.vbase, 2'b00};
    assign ret_target  = q.epc;

    // R6
    trap_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> ret_target == ($past(pc) & ~32'd1));
    // R6
    trap_masks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!q.gie && q.pie == $past(q.gie)));
    // R8
    ret_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> (q.gie == $past(q.pie) && q.pie));
    // R3
    hart_write_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_valid && csr_valid && csr_addr == A_HART && csr_op == 3'b001) |-> trap_take);
    // R10
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_valid |-> (!trap_take && !ret_take));
endmodule

// File: tb/test_csr_trap_unit.sv
module test_csr_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stage_valid, csr_valid, mret;
    logic [31:0] pc, rs1_val, fault_addr, csr_rdata, trap_target, ret_target;
    logic [2:0]  csr_op;
    logic [11:0] csr_addr;
    logic [4:0]  src_field;
    logic        exc_iaddr_mis, exc_illegal, exc_ebreak, exc_ecall, exc_ld_mis, exc_st_mis;
    logic        irq_ext, irq_tmr, irq_sw, trap_take, ret_take;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    csr_trap_unit i_csr_trap_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        stage_valid = 0; csr_valid = 0; mret = 0; pc = 0; rs1_val = 0; fault_addr = 0;
        csr_op = 0; csr_addr = 0; src_field = 0;
        exc_iaddr_mis = 0; exc_illegal = 0; exc_ebreak = 0; exc_ecall = 0;
        exc_ld_mis = 0; exc_st_mis = 0; irq_ext = 0; irq_tmr = 0; irq_sw = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic csr(input logic [2:0] op, input logic [11:0] a, input logic [4:0] f,
                       input logic [31:0] v, output logic [31:0] old, output logic tk);
        idle();
        stage_valid = 1; csr_valid = 1; csr_op = op; csr_addr = a; src_field = f; rs1_val = v;
        pc = 32'h1000;
        #1;
        old = csr_rdata;
        tk = trap_take;
        tick();
        idle();
    endtask

    function automatic logic [31:0] rd_dummy(input logic [31:0] x);
        return x;
    endfunction

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        logic tk;
        csr(3'b010, a, 5'd0, 32'hFFFF_FFFF, v, tk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        logic [31:0] o;
        logic tk;
        csr(3'b001, a, 5'd1, v, o, tk);
    endtask

    // exception vector index: 0 imis,1 ill,2 brk,3 env,4 lmis,5 smis
    task automatic raise(input logic [5:0] ex, input logic [2:0] irq, input logic [31:0] p,
                         input logic [31:0] fa, output logic tk, output logic [31:0] tgt);
        idle();
        stage_valid = 1; pc = p; fault_addr = fa;
        {exc_st_mis, exc_ld_mis, exc_ecall, exc_ebreak, exc_illegal, exc_iaddr_mis} = ex;
        {irq_tmr, irq_sw, irq_ext} = irq;
        #1;
        tk = trap_take;
        tgt = trap_target;
        tick();
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, old, tgt, exp_new, src;
        logic tk;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9 reset values
        rd(12'h300, v); chk("R9 status", v, 32'h1800);
        rd(12'h304, v); chk("R9 enables", v, 0);
        rd(12'h305, v); chk("R9 vector", v, 0);
        rd(12'h341, v); chk("R9 epc", v, 0);
        rd(12'h342, v); chk("R9 cause", v, 0);
        rd(12'h343, v); chk("R9 tval", v, 0);

        // R1 R2 operation sweep on scratch
        for (int o = 0; o < 6; o++) begin
            for (int p = 0; p < 4; p++) begin
                for (int z = 0; z < 2; z++) begin
                    logic [2:0] op;
                    logic [31:0] init, rv;
                    logic [4:0] f;
                    op = (o < 3) ? 3'(o + 1) : 3'(o + 2);
                    init = 32'hA5A5_0F0F ^ (32'h1111_1111 * p);
                    rv = 32'h0000_FF3C + (32'h0137_0000 * p);
                    f = (z == 0) ? 5'd0 : 5'(5'h13 + p * 3);
                    wr(12'h340, init);
                    csr(op, 12'h340, f, rv, old, tk);
                    chk("R1 old value", old, init);
                    src = op[2] ? {27'd0, f} : rv;
                    case (op[1:0])
                        2'b01:   exp_new = src;
                        2'b10:   exp_new = (f == 0) ? init : (init | src);
                        default: exp_new = (f == 0) ? init : (init & ~src);
                    endcase
                    rd(12'h340, v);
                    chk((op[1:0] != 2'b01 && f == 0) ? "R2 no write" : "R1 new value", v, exp_new);
                end
            end
        end

        // R3 illegal accesses
        csr(3'b001, 12'hF14, 5'd1, 32'h5, old, tk); chk("R3 hart write traps", {31'd0, tk}, 1);
        rd(12'h342, v); chk("R3 cause", v, 2);
        rd(12'hF14, v); chk("R3 hart reads zero", v, 0);
        wr(12'h340, 32'h1234_5678);
        csr(3'b001, 12'h7C0, 5'd1, 32'h5, old, tk); chk("R3 unknown traps", {31'd0, tk}, 1);
        csr(3'b001, 12'h344, 5'd2, 32'hFFF, old, tk); chk("R3 pend write traps", {31'd0, tk}, 1);
        rd(12'h340, v); chk("R3 scratch untouched", v, 32'h1234_5678);

        // R6 vector base
        wr(12'h305, 32'h0000_0103);
        rd(12'h305, v); chk("R6 vector low bits", v, 32'h100);

        // R4 R7 single exceptions
        for (int i = 0; i < 6; i++) begin
            logic [31:0] ec, fa;
            fa = 32'hDEAD_0001 + 32'(i * 16);
            case (i)
                0: ec = 0; 1: ec = 2; 2: ec = 3; 3: ec = 11; 4: ec = 4; default: ec = 6;
            endcase
            raise(6'(1 << i), 3'b000, 32'h0000_2003 + 32'(i * 8), fa, tk, tgt);
            chk("R6 trap taken", {31'd0, tk}, 1);
            chk("R6 target", tgt, 32'h100);
            rd(12'h342, v); chk("R4 cause code", v, ec);
            rd(12'h343, v); chk("R7 tval", v, (i == 0 || i == 4 || i == 5) ? fa : 0);
            rd(12'h341, v); chk("R6 epc bit0 clear", v, 32'h0000_2002 + 32'(i * 8));
        end

        // R4 pairwise priority
        raise(6'b000011, 3'b000, 32'h40, 32'h99, tk, tgt); rd(12'h342, v); chk("R4 imis over ill", v, 0);
        raise(6'b001010, 3'b000, 32'h40, 32'h99, tk, tgt); rd(12'h342, v); chk("R4 ill over env", v, 2);
        raise(6'b001100, 3'b000, 32'h40, 32'h99, tk, tgt); rd(12'h342, v); chk("R4 brk over env", v, 3);
        raise(6'b110000, 3'b000, 32'h40, 32'h99, tk, tgt); rd(12'h342, v); chk("R4 load over store", v, 4);

        // R5 gating: enables off
        wr(12'h300, 32'h8);
        raise(6'b0, 3'b111, 32'h50, 0, tk, tgt); chk("R5 no irq without enable bits", {31'd0, tk}, 0);
        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, v); chk("R5 enable bits", v, 32'h888);
        wr(12'h300, 32'h0);
        raise(6'b0, 3'b111, 32'h50, 0, tk, tgt); chk("R5 no irq without global", {31'd0, tk}, 0);

        // R5 pending reflects lines
        idle(); stage_valid = 1; csr_valid = 1; csr_op = 3'b010; csr_addr = 12'h344;
        irq_ext = 1; irq_sw = 1; #1;
        chk("R5 pending view", csr_rdata, 32'h808);
        tick(); idle();

        // R5 R6 priority sweep, bit0 ext, bit1 sw, bit2 tmr
        for (int c = 1; c < 8; c++) begin
            logic [31:0] ec;
            ec = (c & 1) ? 32'h8000_000B : (c & 2) ? 32'h8000_0003 : 32'h8000_0007;
            wr(12'h300, 32'h8);
            raise(6'b0, 3'(c), 32'h0000_3001 + 32'(c * 4), 0, tk, tgt);
            chk("R5 irq taken", {31'd0, tk}, 1);
            rd(12'h342, v); chk("R5 irq cause", v, ec);
            rd(12'h300, v); chk("R6 status after trap", v, 32'h1880);
            rd(12'h341, v); chk("R6 irq epc", v, 32'h0000_3000 + 32'(c * 4));
            rd(12'h343, v); chk("R7 irq tval zero", v, 0);
        end

        // R4 exception beats interrupt
        wr(12'h300, 32'h8);
        raise(6'b010000, 3'b001, 32'h60, 32'h77, tk, tgt);
        rd(12'h342, v); chk("R4 exc over irq", v, 4);

        // R8 trap return, both saved values
        wr(12'h341, 32'h0000_4445);
        wr(12'h300, 32'h80);
        idle(); stage_valid = 1; mret = 1; #1;
        chk("R8 ret taken", {31'd0, ret_take}, 1);
        chk("R8 ret target", ret_target, 32'h4444);
        tick(); idle();
        rd(12'h300, v); chk("R8 status from pie=1", v, 32'h1888);
        wr(12'h300, 32'h8);
        idle(); stage_valid = 1; mret = 1; #1; tick(); idle();
        rd(12'h300, v); chk("R8 status from pie=0", v, 32'h1880);

        // R10 idle slot
        wr(12'h340, 32'hCAFE_0000);
        idle(); csr_valid = 1; csr_op = 3'b001; csr_addr = 12'h340; src_field = 1;
        rs1_val = 32'h1; exc_ecall = 1; mret = 1; #1;
        chk("R10 no trap idle", {30'd0, trap_take, ret_take}, 0);
        tick(); idle();
        rd(12'h340, v); chk("R10 no write idle", v, 32'hCAFE_0000);
        rd(12'h300, v); chk("R10 status unchanged", v, 32'h1880);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, rd_dummy(32'(n_fail)));
        $finish;
    end
endmodule